// File: doc/BRIEF.md
# Packed Signed Byte Maximum Unit

This block is a SIMD execution slice. It treats two 256-bit operands as 32 lanes of 8-bit two's-complement integers. For every active lane it keeps the larger value. It then builds a 256-bit destination word, and three encoding forms decide what goes into the upper half of that word. It sits after operand read in an execution pipeline. Each operation arrives as one strobe carrying a form select, two explicit sources, the current contents of the destination register, and a flag that says whether 256-bit execution is allowed.

The destructive 128-bit form takes the old destination as its first operand and leaves the upper half of the destination untouched. The non-destructive 128-bit form computes from the two explicit sources and clears the upper half. The 256-bit form computes all 32 lanes. If the 256-bit form is requested while wide execution is disabled, or if the reserved form code is used, the block writes no result. It raises an illegal-encoding flag instead and passes the old destination through unchanged.

Top module: `smax8_unit`

## Requirements
- R1: Every lane is compared as a signed 8-bit value. For example, 8'h80 against 8'h7F gives 8'h7F, and 8'hFF against 8'h00 gives 8'h00.
- R2: A lane takes the first operand only when that operand is strictly greater than the second. When the two are equal, the byte from `src_b` is written.
- R3: Form code 2'b00 (destructive 128-bit) uses `dest_old` as the first operand and `src_b` as the second. It computes lanes 0 to 15 (bits 127:0). Bits 255:128 of the result equal `dest_old[255:128]`, and `src_a` has no effect.
- R4: Form code 2'b01 (non-destructive 128-bit) computes lanes 0 to 15 from `src_a` and `src_b`. Bits 255:128 of the result are zero.
- R5: Form code 2'b10 (256-bit) computes all 32 lanes from `src_a` and `src_b` when `wide_en` is 1.
- R6: Form code 2'b10 with `wide_en` at 0 raises `out_illegal` and does not raise `out_valid`.
- R7: Form code 2'b11 is reserved. It raises `out_illegal` and does not raise `out_valid`.
- R8: When `out_illegal` is raised, `out_result` equals the `dest_old` that came with the rejected operation.
- R9: Outputs are registered. They appear on the clock edge after the edge that samples `in_valid`. `out_valid` and `out_illegal` are high only for the cycle that follows an accepted strobe, and they are never both high.
- R10: While `rst_n` is low, `out_valid`, `out_illegal` and `out_result` are all zero.
- R11: In a cycle without `in_valid`, `out_result` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | Encoding form: 00 destructive 128, 01 non-destructive 128, 10 256-bit, 11 reserved |
| wide_en | input | 1 | 256-bit execution permitted |
| src_a | input | 256 | First explicit source |
| src_b | input | 256 | Second source |
| dest_old | input | 256 | Current destination contents |
| out_valid | output | 1 | Result-written pulse |
| out_illegal | output | 1 | Illegal-encoding pulse |
| out_result | output | 256 | Registered destination value |

## Verification
The properties assume that `mode`, `wide_en` and the three operand buses are stable and known at every sampling edge where `in_valid` is high. They make no assumption about these inputs in idle cycles. The stimulus changes every input only on the falling clock edge. It drives random, non-zero data on `src_a` and `dest_old` even in forms that must ignore one of them. This lets a wrong operand choice, or a leak into the upper half, show up in the result. Back-to-back strobes are mixed with idle gaps, so the hold behaviour and the one-cycle pulses are exercised under both spacings.

// File: rtl/smax8_pkg.sv
package smax8_pkg;
  typedef enum logic [1:0] {
    MODE_LEG128 = 2'b00,
    MODE_V128   = 2'b01,
    MODE_V256   = 2'b10,
    MODE_RSVD   = 2'b11
  } smax_mode_e;
endpackage

// File: rtl/smax8_lane.sv
module smax8_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] op_a,
  input  logic [LANE_W-1:0] op_b,
  output logic [LANE_W-1:0] pick
);
  // strict greater-than: ties resolve to op_b
  always_comb begin
    pick = ($signed(op_a) > $signed(op_b)) ? op_a : op_b;
  end

  always_comb begin
    AST_PICK_IS_MAX: assert (($signed(pick) >= $signed(op_a)) && ($signed(pick) >= $signed(op_b))); // R1
  end
endmodule

// File: rtl/smax8_merge.sv
module smax8_merge
  import smax8_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic [1:0]       mode,
  input  logic             wide_en,
  input  logic [VEC_W-1:0] dest_old,
  input  logic [VEC_W-1:0] lane_max,
  output logic [VEC_W-1:0] merged,
  output logic             illegal
);
  localparam int HALF = VEC_W / 2;

  always_comb begin
    illegal = (mode == MODE_RSVD) || ((mode == MODE_V256) && !wide_en);
    unique case (mode)
      MODE_LEG128: merged = {dest_old[VEC_W-1:HALF], lane_max[HALF-1:0]};
      MODE_V128:   merged = {{HALF{1'b0}}, lane_max[HALF-1:0]};
      MODE_V256:   merged = lane_max;
      default:     merged = dest_old;
    endcase
    if (illegal) merged = dest_old;
  end
endmodule

// File: rtl/smax8_unit.sv
module smax8_unit
  import smax8_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic             wide_en,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] dest_old,
  output logic             out_valid,
  output logic             out_illegal,
  output logic [VEC_W-1:0] out_result
);
  localparam int NUM_LANES = VEC_W / LANE_W;
  localparam int HALF      = VEC_W / 2;

  logic [VEC_W-1:0] first_op;
  logic [VEC_W-1:0] lane_max;
  logic [VEC_W-1:0] merged;
  logic             illegal;

  logic [VEC_W-1:0] res_d, res_q;
  logic             vld_d, vld_q;
  logic             ill_d, ill_q;

  // destructive form reads the old destination as its first operand
  always_comb begin
    first_op = (mode == MODE_LEG128) ? dest_old : src_a;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    smax8_lane #(.LANE_W(LANE_W)) lane_i (
      .op_a (first_op[g*LANE_W +: LANE_W]),
      .op_b (src_b[g*LANE_W +: LANE_W]),
      .pick (lane_max[g*LANE_W +: LANE_W])
    );
  end

  smax8_merge #(.VEC_W(VEC_W)) merge_i (
    .mode     (mode),
    .wide_en  (wide_en),
    .dest_old (dest_old),
    .lane_max (lane_max),
    .merged   (merged),
    .illegal  (illegal)
  );

  // next-state
  always_comb begin
    res_d = res_q;
    vld_d = 1'b0;
    ill_d = 1'b0;
    if (in_valid) begin
      res_d = merged;
      vld_d = !illegal;
      ill_d = illegal;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ill_q <= ill_d;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_illegal = ill_q;
  assign out_result  = res_q;

  AST_LEG_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_LEG128) |=> (out_result[VEC_W-1:HALF] == $past(dest_old[VEC_W-1:HALF]))); // R3
  AST_V128_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_V128) |=> (out_result[VEC_W-1:HALF] == '0)); // R4
  AST_WIDE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_V256 && !wide_en) |=> (out_illegal && !out_valid)); // R6
  AST_RSVD_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_RSVD) |=> (out_illegal && !out_valid)); // R7
  AST_TRAP_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_RSVD) |=> (out_result == $past(dest_old))); // R8
  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal)); // R9
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_illegal)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result)); // R11
endmodule

// File: tb/smax8_unit_tb_top.sv
module smax8_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [1:0]    mode;
  logic          wide_en;
  logic [VW-1:0] src_a, src_b, dest_old;
  logic          out_valid, out_illegal;
  logic [VW-1:0] out_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic          exp_vld, exp_ill;
  logic [VW-1:0] exp_res;
  string         cur_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  smax8_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .wide_en(wide_en),
    .src_a(src_a), .src_b(src_b), .dest_old(dest_old),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_result(out_result)
  );

  function automatic logic [7:0] smax(input logic [7:0] x, input logic [7:0] y);
    int sx = $signed(x);
    int sy = $signed(y);
    return (sx > sy) ? x : y;
  endfunction

  function automatic logic [VW-1:0] rnd256();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  task automatic compare();
    n_checks++;
    if (out_valid !== exp_vld || out_illegal !== exp_ill || out_result !== exp_res) begin
      n_fail++;
      $display("FAIL %s: got vld=%b ill=%b res=%h, expected vld=%b ill=%b res=%h",
               cur_tag, out_valid, out_illegal, out_result, exp_vld, exp_ill, exp_res);
    end
  endtask

  // reference model update for the operation just driven
  task automatic model();
    logic [7:0] f;
    if (!in_valid) begin
      exp_vld = 0; exp_ill = 0;
      return;
    end
    if (mode == 2'b11 || (mode == 2'b10 && !wide_en)) begin
      exp_vld = 0; exp_ill = 1; exp_res = dest_old;
      return;
    end
    exp_vld = 1; exp_ill = 0;
    for (int i = 0; i < 32; i++) begin
      f = (mode == 2'b00) ? dest_old[i*8 +: 8] : src_a[i*8 +: 8];
      if (mode == 2'b10 || i < 16) exp_res[i*8 +: 8] = smax(f, src_b[i*8 +: 8]);
      else if (mode == 2'b00)      exp_res[i*8 +: 8] = dest_old[i*8 +: 8];
      else                         exp_res[i*8 +: 8] = 8'h00;
    end
  endtask

  task automatic step(input logic v, input logic [1:0] m, input logic we,
                      input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [VW-1:0] d, input string tag);
    @(negedge clk);
    compare();
    in_valid = v; mode = m; wide_en = we; src_a = a; src_b = b; dest_old = d;
    cur_tag = tag;
    model();
  endtask

  initial begin
    rst_n = 0; in_valid = 0; mode = 0; wide_en = 0;
    src_a = '0; src_b = '0; dest_old = '0;
    exp_vld = 0; exp_ill = 0; exp_res = '0;
    cur_tag = "R10 reset";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;
    // R10: first check after release sees cleared outputs
    step(0, 2'b00, 0, '0, '0, '0, "R10 post-reset");
    // R1 corners in 256-bit form
    step(1, 2'b10, 1, {32{8'h80}}, {32{8'h7F}}, rnd256(), "R1 80vs7F");
    step(1, 2'b10, 1, {32{8'hFF}}, {32{8'h00}}, rnd256(), "R1 FFvs00");
    step(1, 2'b10, 1, {32{8'h7F}}, {32{8'h80}}, rnd256(), "R1 7Fvs80");
    // R2 equality, negative and mixed
    step(1, 2'b10, 1, {32{8'h9C}}, {32{8'h9C}}, rnd256(), "R2 equal neg");
    begin
      logic [VW-1:0] t = rnd256();
      step(1, 2'b01, 0, t, t, rnd256(), "R2 equal mixed");
    end
    // R3 destructive 128: src_a must not matter
    begin
      logic [VW-1:0] d = rnd256();
      logic [VW-1:0] b = rnd256();
      step(1, 2'b00, 0, rnd256(), b, d, "R3 legacy a");
      step(1, 2'b00, 1, ~d, b, d, "R3 legacy b");
    end
    step(1, 2'b00, 1, {32{8'h01}}, {32{8'h80}}, {32{8'hFF}}, "R3 legacy neg");
    // R4 non-destructive 128
    for (int i = 0; i < 6; i++) step(1, 2'b01, i[0], rnd256(), rnd256(), rnd256(), "R4 vex128");
    // R5 256-bit
    for (int i = 0; i < 6; i++) step(1, 2'b10, 1, rnd256(), rnd256(), rnd256(), "R5 vex256");
    // R11 hold across idle
    step(0, 2'b01, 0, rnd256(), rnd256(), rnd256(), "R11 idle");
    step(0, 2'b11, 0, rnd256(), rnd256(), rnd256(), "R11 idle rsvd");
    // R6, R8 wide trap
    step(1, 2'b10, 0, rnd256(), rnd256(), rnd256(), "R6 R8 wide off");
    step(1, 2'b10, 0, {32{8'h7F}}, {32{8'h7F}}, {32{8'h80}}, "R6 R8 wide off b");
    // R7, R8 reserved
    step(1, 2'b11, 1, rnd256(), rnd256(), rnd256(), "R7 R8 rsvd");
    step(1, 2'b11, 0, rnd256(), rnd256(), rnd256(), "R7 R8 rsvd b");
    step(0, 2'b00, 0, '0, '0, '0, "R9 idle after trap");
    // R9 mixed spacing
    for (int i = 0; i < 40; i++)
      step(logic'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), logic'($urandom_range(0, 1)),
           rnd256(), rnd256(), rnd256(), "R9 mixed");
    step(0, 2'b00, 0, '0, '0, '0, "R9 drain");
    // R10 reset in mid-run clears outputs
    step(1, 2'b10, 1, {32{8'h11}}, {32{8'h22}}, '0, "R10 pre");
    @(negedge clk);
    compare();
    in_valid = 0;
    rst_n = 0;
    exp_vld = 0; exp_ill = 0; exp_res = '0;
    cur_tag = "R10 async reset";
    #1;
    compare();
    @(negedge clk);
    rst_n = 1;
    compare();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule